// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block resolves a translation miss by walking a radix page table held in memory. When the translation cache reports a miss for a virtual page number, the walker takes the table root from an input register. It reads one table entry per level through a request/response memory port. Each valid entry that is not the last one gives the base of the table for the next level. When the leaf entry is valid, its frame number goes back to the translation cache with a one-cycle fill strobe.

If the valid bit is clear in any entry the walker reads, it stops at once. It makes no fill and pulses a page-fault output instead. It then goes back to idle. Loading the page, repairing the table and restarting the access are left to software. A later retry of the same access starts a completely new walk.

The number of levels, the index width per level, the entry size in bytes, the address width, the frame width and the page shift are all parameters. The entry size does not have to be a power of two.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `mem_req_valid`, `fill_valid` and `fault` are all low.
- R2: `miss_valid` starts a walk only while `busy` is low, and `busy` is high on the cycle after it is accepted. While `busy` is high, `miss_valid` and `miss_vpn` have no effect on the memory reads, on the reported result or on the state after the walk.
- R3: The page number is cut into `LEVELS` index fields of `IDX_W` bits each, used from the most significant field down. For each level, the read address is the current table base plus the index times `ENTRY_BYTES`, taken modulo 2^`ADDR_W`. The first table base is `root_base`.
- R4: Each level issues exactly one read, so a walk that succeeds makes exactly `LEVELS` reads. While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address are held unchanged.
- R5: At most one read is outstanding. After a request handshake, no new request is raised until `mem_rsp_valid` has returned.
- R6: An entry carries its valid flag in bit 0 and its frame number in bits `PFN_W`:1. The table base for the next level is the frame number shifted left by `PAGE_SH`.
- R7: When the leaf entry is valid, `fill_valid` is high for exactly one cycle. In that cycle `fill_pfn` is the leaf frame number and `fill_vpn` is the page number of the walk.
- R8: An entry with a clear valid bit at level k ends the walk after k+1 reads. `fault` is then high for one cycle, and `fill_valid` does not pulse for that walk.
- R9: In the cycle `fill_valid` or `fault` is shown, `busy` is low. A miss presented in that cycle is accepted and starts a new walk, and a retry after a fault repeats the full walk from the root.
- R10: `fill_valid` and `fault` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Translation miss, request to walk |
| miss_vpn | input | LEVELS*IDX_W | Virtual page number that missed |
| root_base | input | ADDR_W | Byte address of the top-level table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is returned |
| mem_rsp_data | input | PFN_W+1 | Entry read: frame number above a valid bit |
| fill_valid | output | 1 | One-cycle strobe that fills the translation cache |
| fill_vpn | output | LEVELS*IDX_W | Page number that belongs to the fill or fault |
| fill_pfn | output | PFN_W | Frame number for the fill |
| fault | output | 1 | One-cycle page-fault strobe |

## Verification
Two functions can fall in the same cycle: a walk reporting its fill or fault, and a new miss being accepted. The bench provokes this by raising `miss_valid` on exactly the cycle the result strobe is seen. It then judges that the old result stays intact, that `busy` rises on the next cycle, and that the new walk resolves to its own computed frame. It also presents a miss in the middle of a walk and confirms that the read count and the result belong only to the first walk. The bench sweeps every page number of a two-level configuration and of a four-level configuration with a non-power-of-two entry size, using a table model whose contents are computed arithmetically.

// File: rtl/pw_pkg.sv
package pw_pkg;

   typedef enum logic [1:0] {
      PW_IDLE  = 2'd0,
      PW_ISSUE = 2'd1,
      PW_WAIT  = 2'd2
   } pw_state_e;

   // bit position of the valid flag inside an entry
   localparam int PTE_VALID_BIT = 0;

endpackage

// File: rtl/pw_index.sv
// Selects the index field for the current level, most significant first.
module pw_index #(
   parameter int LEVELS = 2,
   parameter int IDX_W  = 3,
   parameter int LVL_W  = 1,
   localparam int VPN_W = LEVELS * IDX_W
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [LVL_W-1:0] level,
   output logic [IDX_W-1:0] idx
);

   logic [IDX_W-1:0] fld [LEVELS];

   for (genvar g = 0; g < LEVELS; g++) begin : g_fld
      assign fld[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
   end

   if (LEVELS == 1) begin : g_single
      logic unused_level;
      assign unused_level = ^level;
      assign idx = fld[0];
   end else begin : g_multi
      always_comb begin
         idx = '0;
         for (int g = 0; g < LEVELS; g++) begin
            if (int'(level) == g) idx = fld[g];
         end
      end
   end

endmodule

// File: rtl/pw_addr.sv
// Entry address = table base + index * entry size (modulo address width).
module pw_addr #(
   parameter int ADDR_W      = 16,
   parameter int IDX_W       = 3,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);

   localparam bit EB_POW2 = (ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0;
   localparam int EB_SH   = (ENTRY_BYTES > 1) ? $clog2(ENTRY_BYTES) : 0;

   logic [ADDR_W-1:0] off;

   if (EB_POW2) begin : g_shift
      assign off = ADDR_W'(idx) << EB_SH;
   end else begin : g_mult
      assign off = ADDR_W'(idx) * ADDR_W'(ENTRY_BYTES);
   end

   assign addr = base + off;

endmodule

// File: rtl/pw_fsm.sv
// Sequencer: accepts a miss, issues one entry read per level, reports fill or fault.
module pw_fsm
   import pw_pkg::*;
#(
   parameter int LEVELS  = 2,
   parameter int IDX_W   = 3,
   parameter int ADDR_W  = 16,
   parameter int PFN_W   = 10,
   parameter int PAGE_SH = 6,
   parameter int LVL_W   = 1,
   localparam int VPN_W  = LEVELS * IDX_W,
   localparam int PTE_W  = PFN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [VPN_W-1:0]  miss_vpn,
   input  logic [ADDR_W-1:0] root_base,
   input  logic              mem_req_ready,
   input  logic              mem_rsp_valid,
   input  logic [PTE_W-1:0]  mem_rsp_data,
   output logic [LVL_W-1:0]  level,
   output logic [ADDR_W-1:0] base,
   output logic [VPN_W-1:0]  vpn_q,
   output logic              busy,
   output logic              mem_req_valid,
   output logic              fill_valid,
   output logic [PFN_W-1:0]  fill_pfn,
   output logic              fault
);

   localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);

   pw_state_e         state;
   logic              pte_ok;
   logic [PFN_W-1:0]  pte_pfn;
   logic [ADDR_W-1:0] next_base;

   assign pte_ok    = mem_rsp_data[PTE_VALID_BIT];
   assign pte_pfn   = mem_rsp_data[PFN_W:1];
   assign next_base = ADDR_W'(pte_pfn) << PAGE_SH;

   assign busy          = (state != PW_IDLE);
   assign mem_req_valid = (state == PW_ISSUE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= PW_IDLE;
         level      <= '0;
         base       <= '0;
         vpn_q      <= '0;
         fill_valid <= 1'b0;
         fill_pfn   <= '0;
         fault      <= 1'b0;
      end else begin
         fill_valid <= 1'b0;
         fault      <= 1'b0;
         unique case (state)
            PW_IDLE: begin
               if (miss_valid) begin
                  vpn_q <= miss_vpn;
                  base  <= root_base;
                  level <= '0;
                  state <= PW_ISSUE;
               end
            end
            PW_ISSUE: begin
               if (mem_req_ready) state <= PW_WAIT;
            end
            PW_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!pte_ok) begin
                     fault <= 1'b1;
                     state <= PW_IDLE;
                  end else if (level == LAST) begin
                     fill_valid <= 1'b1;
                     fill_pfn   <= pte_pfn;
                     state      <= PW_IDLE;
                  end else begin
                     base  <= next_base;
                     level <= level + LVL_W'(1);
                     state <= PW_ISSUE;
                  end
               end
            end
            default: state <= PW_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
   parameter int LEVELS      = 2,
   parameter int IDX_W       = 3,
   parameter int ENTRY_BYTES = 4,
   parameter int ADDR_W      = 16,
   parameter int PFN_W       = 10,
   parameter int PAGE_SH     = 6,
   localparam int VPN_W      = LEVELS * IDX_W,
   localparam int PTE_W      = PFN_W + 1,
   localparam int LVL_W      = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [VPN_W-1:0]  miss_vpn,
   input  logic [ADDR_W-1:0] root_base,
   output logic              busy,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [PTE_W-1:0]  mem_rsp_data,
   output logic              fill_valid,
   output logic [VPN_W-1:0]  fill_vpn,
   output logic [PFN_W-1:0]  fill_pfn,
   output logic              fault
);

   if (LEVELS < 1)             begin : g_bad_levels $error("LEVELS must be at least 1"); end
   if (IDX_W < 1)              begin : g_bad_idx    $error("IDX_W must be at least 1"); end
   if (ENTRY_BYTES < 1)        begin : g_bad_eb     $error("ENTRY_BYTES must be at least 1"); end
   if (PFN_W < 1)              begin : g_bad_pfn    $error("PFN_W must be at least 1"); end
   if (PAGE_SH >= ADDR_W)      begin : g_bad_sh     $error("PAGE_SH must be below ADDR_W"); end

   logic [LVL_W-1:0]  level;
   logic [ADDR_W-1:0] base;
   logic [VPN_W-1:0]  vpn_q;
   logic [IDX_W-1:0]  idx;

   pw_fsm #(
      .LEVELS (LEVELS),
      .IDX_W  (IDX_W),
      .ADDR_W (ADDR_W),
      .PFN_W  (PFN_W),
      .PAGE_SH(PAGE_SH),
      .LVL_W  (LVL_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .miss_valid   (miss_valid),
      .miss_vpn     (miss_vpn),
      .root_base    (root_base),
      .mem_req_ready(mem_req_ready),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data),
      .level        (level),
      .base         (base),
      .vpn_q        (vpn_q),
      .busy         (busy),
      .mem_req_valid(mem_req_valid),
      .fill_valid   (fill_valid),
      .fill_pfn     (fill_pfn),
      .fault        (fault)
   );

   pw_index #(
      .LEVELS(LEVELS),
      .IDX_W (IDX_W),
      .LVL_W (LVL_W)
   ) u_index (
      .vpn  (vpn_q),
      .level(level),
      .idx  (idx)
   );

   pw_addr #(
      .ADDR_W     (ADDR_W),
      .IDX_W      (IDX_W),
      .ENTRY_BYTES(ENTRY_BYTES)
   ) u_addr (
      .base(base),
      .idx (idx),
      .addr(mem_req_addr)
   );

   assign fill_vpn = vpn_q;

endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
   parameter int ADDR_W = 16,
   parameter int PFN_W  = 10,
   localparam int PTE_W = PFN_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              miss_valid,
   input logic              busy,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              mem_rsp_valid,
   input logic [PTE_W-1:0]  mem_rsp_data,
   input logic              fill_valid,
   input logic [PFN_W-1:0]  fill_pfn,
   input logic              fault
);

   logic [1:0] outst;

   always_ff @(posedge clk) begin
      if (!rst_n) outst <= '0;
      else outst <= outst + 2'(mem_req_valid && mem_req_ready) - 2'(mem_rsp_valid);
   end

   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && miss_valid) |=> busy);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid);

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   assert_one_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (outst == 2'd0));

   assert_fill_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> ($past(mem_rsp_valid && mem_rsp_data[0]) &&
                      fill_pfn == $past(mem_rsp_data[PFN_W:1])));

   assert_fill_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |=> !fill_valid);

   assert_fault_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $past(mem_rsp_valid && !mem_rsp_data[0]));

   assert_result_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid || fault) |-> !busy);

   assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_valid && fault));

endmodule

bind pt_walker pw_checker #(
   .ADDR_W(ADDR_W),
   .PFN_W (PFN_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .miss_valid   (miss_valid),
   .busy         (busy),
   .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready),
   .mem_req_addr (mem_req_addr),
   .mem_rsp_valid(mem_rsp_valid),
   .mem_rsp_data (mem_rsp_data),
   .fill_valid   (fill_valid),
   .fill_pfn     (fill_pfn),
   .fault        (fault)
);

// File: tb/sim_pt_walker.sv
package sim_pt_pkg;
   function automatic bit ent_ok(input int a);
      return ((a >> 2) % 11) != 4;
   endfunction

   function automatic int ent_pfn(input int a, input int pfnw);
      return ((a >> 2) * 37 + 5) & ((1 << pfnw) - 1);
   endfunction

   function automatic void exp_walk(input int root, input int vpn, input int levels,
                                    input int idxw, input int eb, input int psh,
                                    input int pfnw, input int addrw,
                                    output bit flt, output int pfn, output int nrd);
      int base;
      int mask;
      mask = (1 << addrw) - 1;
      base = root;
      flt = 0; pfn = 0; nrd = 0;
      for (int l = 0; l < levels; l++) begin
         int idx;
         int a;
         idx = (vpn >> ((levels - 1 - l) * idxw)) & ((1 << idxw) - 1);
         a = (base + idx * eb) & mask;
         nrd++;
         if (!ent_ok(a)) begin
            flt = 1;
            return;
         end
         pfn = ent_pfn(a, pfnw);
         base = (pfn << psh) & mask;
      end
   endfunction
endpackage

module sim_mem #(
   parameter int ADDR_W = 16,
   parameter int PFN_W  = 10,
   parameter int PHASE  = 1
) (
   input  logic              clk,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic [PFN_W:0]    rsp_data,
   output int                reads
);
   import sim_pt_pkg::*;
   int cnt = 0;
   int dly = 0;
   bit pend = 0;
   int la = 0;

   initial begin
      rsp_valid = 0;
      rsp_data = '0;
      reads = 0;
   end

   assign req_ready = (cnt % 3) != PHASE;

   always @(posedge clk) begin
      cnt <= cnt + 1;
      rsp_valid <= 1'b0;
      if (pend) begin
         if (dly == 0) begin
            rsp_valid <= 1'b1;
            rsp_data  <= {PFN_W'(ent_pfn(la, PFN_W)), ent_ok(la)};
            pend <= 0;
         end else begin
            dly <= dly - 1;
         end
      end
      if (req_valid && req_ready) begin
         pend  <= 1;
         la    <= int'(req_addr);
         dly   <= cnt % 2;
         reads <= reads + 1;
      end
   end
endmodule

module sim_pt_walker;
   import sim_pt_pkg::*;

   localparam int CLK_PERIOD = 10;

   // configuration 0: two levels, power-of-two entries
   localparam int L0 = 2, X0 = 3, E0 = 4;
   // configuration 1: four levels, six-byte entries
   localparam int L1 = 4, X1 = 2, E1 = 6;
   localparam int AW = 16, PW = 10, SH = 6;

   logic clk = 0;
   logic rst_n = 0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   // instance 0 signals
   logic mv0 = 0;
   logic [L0*X0-1:0] vpn0 = '0;
   logic [AW-1:0] root0 = '0;
   logic busy0, rqv0, rqr0, rsv0, fill0, flt0;
   logic [AW-1:0] rqa0;
   logic [PW:0] rsd0;
   logic [L0*X0-1:0] fvpn0;
   logic [PW-1:0] fpfn0;
   int rd0;

   // instance 1 signals
   logic mv1 = 0;
   logic [L1*X1-1:0] vpn1 = '0;
   logic [AW-1:0] root1 = '0;
   logic busy1, rqv1, rqr1, rsv1, fill1, flt1;
   logic [AW-1:0] rqa1;
   logic [PW:0] rsd1;
   logic [L1*X1-1:0] fvpn1;
   logic [PW-1:0] fpfn1;
   int rd1;

   pt_walker #(.LEVELS(L0), .IDX_W(X0), .ENTRY_BYTES(E0), .ADDR_W(AW), .PFN_W(PW), .PAGE_SH(SH)) u0 (
      .clk(clk), .rst_n(rst_n), .miss_valid(mv0), .miss_vpn(vpn0), .root_base(root0),
      .busy(busy0), .mem_req_valid(rqv0), .mem_req_ready(rqr0), .mem_req_addr(rqa0),
      .mem_rsp_valid(rsv0), .mem_rsp_data(rsd0), .fill_valid(fill0), .fill_vpn(fvpn0),
      .fill_pfn(fpfn0), .fault(flt0));

   sim_mem #(.ADDR_W(AW), .PFN_W(PW), .PHASE(1)) m0 (
      .clk(clk), .req_valid(rqv0), .req_ready(rqr0), .req_addr(rqa0),
      .rsp_valid(rsv0), .rsp_data(rsd0), .reads(rd0));

   pt_walker #(.LEVELS(L1), .IDX_W(X1), .ENTRY_BYTES(E1), .ADDR_W(AW), .PFN_W(PW), .PAGE_SH(SH)) u1 (
      .clk(clk), .rst_n(rst_n), .miss_valid(mv1), .miss_vpn(vpn1), .root_base(root1),
      .busy(busy1), .mem_req_valid(rqv1), .mem_req_ready(rqr1), .mem_req_addr(rqa1),
      .mem_rsp_valid(rsv1), .mem_rsp_data(rsd1), .fill_valid(fill1), .fill_vpn(fvpn1),
      .fill_pfn(fpfn1), .fault(flt1));

   sim_mem #(.ADDR_W(AW), .PFN_W(PW), .PHASE(2)) m1 (
      .clk(clk), .req_valid(rqv1), .req_ready(rqr1), .req_addr(rqa1),
      .rsp_valid(rsv1), .rsp_data(rsd1), .reads(rd1));

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic bit pulse(input int w);
      return (w == 0) ? (fill0 || flt0) : (fill1 || flt1);
   endfunction

   // Wait at falling edges until a result strobe; checks first request address (R3).
   task automatic wait_result(input int w, input int exp_addr0, input bit chk_addr);
      int n = 0;
      bit seen = 0;
      while (!pulse(w) && n < 400) begin
         if (!seen && ((w == 0) ? rqv0 : rqv1)) begin
            seen = 1;
            if (chk_addr) chk(int'((w == 0) ? rqa0 : rqa1) == exp_addr0, "R3", "first entry address",
                              int'((w == 0) ? rqa0 : rqa1), exp_addr0);
         end
         @(negedge clk);
         n++;
      end
      if (n >= 400) chk(0, "R7", "walk timeout", n, 0);
   endtask

   task automatic judge(input int w, input int vpn, input int root, input int r_before);
      bit ef; int ep; int en;
      int lv, xw, eb;
      bit f, fl; int p, fv, rd;
      lv = (w == 0) ? L0 : L1;
      xw = (w == 0) ? X0 : X1;
      eb = (w == 0) ? E0 : E1;
      exp_walk(root, vpn, lv, xw, eb, SH, PW, AW, ef, ep, en);
      f  = (w == 0) ? flt0 : flt1;
      fl = (w == 0) ? fill0 : fill1;
      p  = (w == 0) ? int'(fpfn0) : int'(fpfn1);
      fv = (w == 0) ? int'(fvpn0) : int'(fvpn1);
      rd = (w == 0) ? rd0 : rd1;
      chk(!(f && fl), "R10", "fill and fault together", int'(f), 0);
      if (ef) begin
         chk(f && !fl, "R8", "fault without fill", {f, fl}, 2);
         chk(rd - r_before == en, "R8", "reads before abort", rd - r_before, en);
      end else begin
         chk(fl && !f, "R7", "fill strobe", {f, fl}, 1);
         chk(p == ep, "R7 R6", "fill frame", p, ep);
         chk(fv == vpn, "R7", "fill page number", fv, vpn);
         chk(rd - r_before == lv, "R4", "reads per walk", rd - r_before, lv);
      end
      chk(((w == 0) ? busy0 : busy1) == 1'b0, "R9", "busy low with result",
          int'((w == 0) ? busy0 : busy1), 0);
   endtask

   task automatic run(input int w, input int vpn, input int root);
      int rb;
      int a0;
      int xw, lv, eb;
      lv = (w == 0) ? L0 : L1;
      xw = (w == 0) ? X0 : X1;
      eb = (w == 0) ? E0 : E1;
      a0 = (root + ((vpn >> ((lv - 1) * xw)) & ((1 << xw) - 1)) * eb) & ((1 << AW) - 1);
      rb = (w == 0) ? rd0 : rd1;
      if (w == 0) begin mv0 = 1; vpn0 = (L0*X0)'(vpn); root0 = AW'(root); end
      else        begin mv1 = 1; vpn1 = (L1*X1)'(vpn); root1 = AW'(root); end
      @(negedge clk);
      if (w == 0) mv0 = 0; else mv1 = 0;
      chk(((w == 0) ? busy0 : busy1) == 1'b1, "R2", "busy after accept", 0, 1);
      wait_result(w, a0, 1);
      judge(w, vpn, root, rb);
      @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy0 && !rqv0 && !fill0 && !flt0 && !busy1 && !rqv1, "R1", "outputs in reset",
          {busy0, rqv0, fill0, flt0}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(!busy0 && !rqv0 && !fill0 && !flt0 && !busy1 && !rqv1, "R1", "outputs after reset",
          {busy0, rqv0, fill0, flt0}, 0);

      // full sweep, two roots, two levels; retry every fault (R9)
      for (int r = 0; r < 2; r++) begin
         for (int v = 0; v < (1 << (L0*X0)); v++) begin
            bit ef; int ep; int en;
            int root;
            root = (r == 0) ? 'h0100 : 'h2A40;
            run(0, v, root);
            exp_walk(root, v, L0, X0, E0, SH, PW, AW, ef, ep, en);
            if (ef) run(0, v, root); // R9 retry walks again from the root
         end
      end

      // full sweep, four levels, six-byte entries
      for (int v = 0; v < (1 << (L1*X1)); v++) run(1, v, 'h0344);

      // R2: miss while busy is ignored
      begin
         int rb; int rb2;
         rb = rd0;
         mv0 = 1; vpn0 = 6'd3; root0 = 16'h0100;
         @(negedge clk); mv0 = 0;
         @(negedge clk);
         mv0 = 1; vpn0 = 6'd50;
         @(negedge clk); mv0 = 0;
         wait_result(0, 0, 0);
         judge(0, 3, 'h0100, rb);
         rb2 = rd0;
         repeat (12) @(negedge clk);
         chk(rd0 == rb2 && !busy0, "R2", "no walk from ignored miss", rd0 - rb2, 0);
      end

      // R9: new miss accepted in the result cycle
      begin
         int rb; int rb2;
         rb = rd0;
         mv0 = 1; vpn0 = 6'd9; root0 = 16'h0100;
         @(negedge clk); mv0 = 0;
         wait_result(0, 0, 0);
         judge(0, 9, 'h0100, rb);
         rb2 = rd0;
         mv0 = 1; vpn0 = 6'd20;
         @(negedge clk); mv0 = 0;
         chk(busy0 == 1'b1 && !fill0 && !flt0, "R9", "walk starts after result cycle", int'(busy0), 1);
         wait_result(0, 0, 0);
         judge(0, 20, 'h0100, rb2);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule